// File: doc/BRIEF.md
# Bridge Target Read Prefetch Sequencer

This block works on the target side of a bridge that connects PCI to a processor bus. After a PCI memory read has been claimed, the block decides how many bytes to fetch ahead from the destination bus. It then issues that fetch as a series of 8-byte read beats. The decision uses the decoded read command and a set of control fields that belong to the window the read hit: an alias enable, a 3-bit fetch-size code, a cache line size in 32-bit words, a narrow (4-byte) access bit and an endian mode.

A request is taken in a single cycle while `req_ready` is high. One cycle is then spent sizing the fetch. During that cycle the count is cut so that it ends at the next 4 KB page boundary, and an illegal narrow/endian combination is detected. Beats follow at consecutive 8-byte-aligned addresses, and each one stays on the outputs until the downstream side accepts it. A one-cycle `done` pulse closes each request. An illegal setting gives a one-cycle `err` pulse in place of any beats.

Command encoding on `req_cmd`: 2'b00 is a plain memory read, 2'b01 is a read-line, 2'b10 is a read-multiple, and 2'b11 is handled the same as a plain memory read.

Top module: `pf_read_seq`

## Requirements
- R1: A plain memory read with the alias enable clear and the narrow bit clear fetches exactly 8 bytes: one beat with byte enables 8'hFF.
- R2: A plain memory read with the alias enable set (narrow bit clear) fetches 8 × 2^code bytes. Codes of 3'b100 and above all give 128 bytes (16 beats).
- R3: A read-line fetches line_words × 4 bytes, rounded up to whole 8-byte beats. A line size of zero gives one beat.
- R4: A read-multiple fetches the larger of 32 bytes and 8 × 2^min(code,4) bytes, whatever the alias enable holds.
- R5: No fetch crosses a 4 KB boundary. The beat count is cut so that the last beat is the one whose address ends the page.
- R6: With the narrow bit set, a plain memory read is a single beat with 4 byte enables: 8'h0F when address bit 2 is 0 and 8'hF0 when it is 1. Read-line and read-multiple keep their normal size and use byte enables 8'hFF.
- R7: With the narrow bit set and endian mode 2'b00, no beat is issued for any command. `err` is high for exactly one cycle (the cycle after acceptance) and `done` follows in the next cycle. Endian modes 2'b01, 2'b10 and 2'b11 are legal.
- R8: The first beat address is the request address with bits [2:0] cleared, and each later beat adds 8. A beat holds its address and enables while `beat_ready` is low and advances only on a cycle where `beat_ready` is high.
- R9: `req_ready` is high only when the block is idle. A request presented while it is low is ignored and does not change the beats being issued.
- R10: `done` is a one-cycle pulse in the cycle after the last beat is accepted, and `req_ready` returns in the cycle after that.
- R11: After reset, `req_ready` is 1 and `beat_valid`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Claimed read request present |
| req_cmd | input | 2 | Read command code |
| req_addr | input | ADDR_W | Start byte address |
| alias_en | input | 1 | Plain reads use the size code |
| size_code | input | 3 | Fetch size code |
| line_words | input | LINE_W | Cache line size in 32-bit words |
| narrow_mode | input | 1 | 4-byte access mode |
| endian_mode | input | 2 | Endian setting of the window |
| req_ready | output | 1 | Block is idle and takes a request |
| beat_valid | output | 1 | Read beat request valid |
| beat_addr | output | ADDR_W | 8-byte-aligned beat address |
| beat_be | output | 8 | Byte enables of the beat |
| beat_ready | input | 1 | Downstream accepts the beat |
| done | output | 1 | Request finished pulse |
| err | output | 1 | Illegal narrow/endian pulse |

## Verification
Two pairs of events can fall in the same cycle. A page cut can coincide with the final accepted beat, and a stall can coincide with the beat that ends the page. The bench starts read-multiple and aliased plain reads a few beats below a 4 KB boundary and drops `beat_ready` in a fixed pattern. It then judges, on every cycle, that the last beat sent is the one ending the page and that `done` comes exactly one cycle after it is accepted. A second coincidence is a new request held on `req_valid` while beats are still being issued. The reference model accepts that request only once the block is idle again, and every beat address is compared against the model.

// File: rtl/pf_seq_pkg.sv
package pf_seq_pkg;
  localparam int BEAT_BYTES    = 8;
  localparam int BEAT_SHIFT    = 3;
  localparam int MRM_MIN_BEATS = 4;

  typedef enum logic [1:0] {
    CMD_MR  = 2'b00,
    CMD_MRL = 2'b01,
    CMD_MRM = 2'b10,
    CMD_RSV = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_CALC  = 2'b01,
    ST_ISSUE = 2'b10,
    ST_DONE  = 2'b11
  } state_e;
endpackage

// File: rtl/pf_size_calc.sv
module pf_size_calc
  import pf_seq_pkg::*;
#(
  parameter int LINE_W    = 8,
  parameter int CNT_W     = 10,
  parameter int MAX_SHIFT = 4
) (
  input  cmd_e              cmd,
  input  logic              alias_en,
  input  logic [2:0]        size_code,
  input  logic [LINE_W-1:0] line_words,
  input  logic              narrow,
  output logic [CNT_W-1:0]  beats,
  output logic              lane_only
);
  logic [2:0]        code_sat;
  logic [CNT_W-1:0]  code_beats;
  logic [LINE_W:0]   lw_sum;
  logic [CNT_W-1:0]  line_beats;
  logic [CNT_W-1:0]  multi_beats;

  always_comb begin
    code_sat   = (size_code > 3'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : size_code;
    code_beats = CNT_W'(1) << code_sat;
    lw_sum     = {1'b0, line_words} + {{LINE_W{1'b0}}, 1'b1};
    line_beats = CNT_W'(lw_sum[LINE_W:1]);
    if (line_beats == '0) begin
      line_beats = CNT_W'(1);
    end
    multi_beats = (code_beats < CNT_W'(MRM_MIN_BEATS)) ? CNT_W'(MRM_MIN_BEATS) : code_beats;
  end

  always_comb begin
    lane_only = 1'b0;
    unique case (cmd)
      CMD_MRL: beats = line_beats;
      CMD_MRM: beats = multi_beats;
      default: begin
        if (narrow) begin
          beats     = CNT_W'(1);
          lane_only = 1'b1;
        end else if (alias_en) begin
          beats = code_beats;
        end else begin
          beats = CNT_W'(1);
        end
      end
    endcase
  end
endmodule

// File: rtl/pf_page_clip.sv
module pf_page_clip
  import pf_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int CNT_W     = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  want,
  output logic [CNT_W-1:0]  beats
);
  localparam int OFF_W      = PAGE_BITS - BEAT_SHIFT;
  localparam int PAGE_BEATS = 1 << OFF_W;

  logic [CNT_W-1:0] room;

  always_comb begin
    room  = CNT_W'(PAGE_BEATS) - CNT_W'(addr[PAGE_BITS-1:BEAT_SHIFT]);
    beats = (want > room) ? room : want;
  end
endmodule

// File: rtl/pf_read_seq.sv
module pf_read_seq
  import pf_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_W     = 8,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_SHIFT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              alias_en,
  input  logic [2:0]        size_code,
  input  logic [LINE_W-1:0] line_words,
  input  logic              narrow_mode,
  input  logic [1:0]        endian_mode,
  output logic              req_ready,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [7:0]        beat_be,
  input  logic              beat_ready,
  output logic              done,
  output logic              err
);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);
  localparam int CNT_W     = PAGE_BITS - BEAT_SHIFT + 1;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  state_e            state_q, state_d;
  cmd_e              cap_cmd_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic              cap_alias_q, cap_narrow_q;
  logic [2:0]        cap_code_q;
  logic [LINE_W-1:0] cap_lw_q;
  logic [1:0]        cap_endian_q;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        be_q, be_d;

  logic              accept, fire, illegal, lane_only;
  logic              cnt_en;
  logic [CNT_W-1:0]  want_beats, clip_beats;

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign fire    = (state_q == ST_ISSUE) && beat_ready;
  assign illegal = cap_narrow_q && (cap_endian_q == 2'b00);

  pf_size_calc #(.LINE_W(LINE_W), .CNT_W(CNT_W), .MAX_SHIFT(MAX_SHIFT)) u_size (
    .cmd        (cap_cmd_q),
    .alias_en   (cap_alias_q),
    .size_code  (cap_code_q),
    .line_words (cap_lw_q),
    .narrow     (cap_narrow_q),
    .beats      (want_beats),
    .lane_only  (lane_only)
  );

  pf_page_clip #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .CNT_W(CNT_W)) u_clip (
    .addr  (cap_addr_q),
    .want  (want_beats),
    .beats (clip_beats)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_CALC;
      ST_CALC:  state_d = illegal ? ST_DONE : ST_ISSUE;
      ST_ISSUE: if (beat_ready && (cnt_q == CNT_W'(1))) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // beat counter and address
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    be_d   = be_q;
    if (state_q == ST_CALC) begin
      cnt_en = 1'b1;
      cnt_d  = clip_beats;
      addr_d = {cap_addr_q[ADDR_W-1:BEAT_SHIFT], {BEAT_SHIFT{1'b0}}};
      be_d   = lane_only ? (cap_addr_q[2] ? 8'hF0 : 8'h0F) : 8'hFF;
    end else if (fire) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_W'(1);
      addr_d = addr_q + ADDR_W'(BEAT_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      cap_cmd_q    <= cmd_e'(req_cmd);
      cap_addr_q   <= req_addr;
      cap_alias_q  <= alias_en;
      cap_code_q   <= size_code;
      cap_lw_q     <= line_words;
      cap_narrow_q <= narrow_mode;
      cap_endian_q <= endian_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (cnt_en) begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      be_q   <= be_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign beat_valid = (state_q == ST_ISSUE);
  assign beat_addr  = addr_q;
  assign beat_be    = be_q;
  assign done       = (state_q == ST_DONE);
  assign err        = (state_q == ST_CALC) && illegal;
endmodule

// File: rtl/pf_read_seq_chk.sv
module pf_read_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              beat_valid,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [7:0]        beat_be,
  input logic              beat_ready,
  input logic              done,
  input logic              err
);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R10
  AST_ERR_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> done); // R7
  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !beat_valid && !done); // R7
  AST_BEAT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_addr[2:0] == 3'b000)); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_be)); // R8
  AST_STEP_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready |=> !beat_valid || (beat_addr == $past(beat_addr) + ADDR_W'(8))); // R8
  AST_PAGE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && (beat_addr[PAGE_BITS-1:3] == '1) |=> done); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !beat_valid && !done && !err); // R9
  AST_BE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_be != 8'h00)); // R6
endmodule

bind pf_read_seq pf_read_seq_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .beat_valid (beat_valid),
  .beat_addr  (beat_addr),
  .beat_be    (beat_be),
  .beat_ready (beat_ready),
  .done       (done),
  .err        (err)
);

// File: tb/pf_read_seq_tb.sv
module pf_read_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_cmd = 2'b00;
  logic [31:0] req_addr = '0;
  logic        alias_en = 1'b0;
  logic [2:0]  size_code = '0;
  logic [7:0]  line_words = '0;
  logic        narrow_mode = 1'b0;
  logic [1:0]  endian_mode = 2'b10;
  logic        beat_ready = 1'b0;
  logic        req_ready, beat_valid, done, err;
  logic [31:0] beat_addr;
  logic [7:0]  beat_be;

  int checks = 0;
  int bad = 0;
  int stall_mode = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pf_read_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .alias_en(alias_en), .size_code(size_code),
    .line_words(line_words), .narrow_mode(narrow_mode), .endian_mode(endian_mode),
    .req_ready(req_ready), .beat_valid(beat_valid), .beat_addr(beat_addr),
    .beat_be(beat_be), .beat_ready(beat_ready), .done(done), .err(err)
  );

  // reference model
  int          m_phase = 0;
  logic [31:0] m_q[$];
  logic [7:0]  m_be;
  logic        m_illegal = 1'b0;
  logic [1:0]  c_cmd;
  logic [31:0] c_addr;
  logic        c_alias, c_narrow;
  logic [2:0]  c_code;
  logic [7:0]  c_lw;
  logic [1:0]  c_endian;
  int          beats_seen = 0;
  int          errs_seen = 0;

  function automatic int pow_amt(input logic [2:0] code);
    int k;
    k = (code > 3'd4) ? 4 : int'(code);
    return 8 * (1 << k);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_phase = 0;
      m_q.delete();
    end else begin
      if (beat_valid && beat_ready) beats_seen++;
      if (err) errs_seen++;
      case (m_phase)
        0: if (req_valid) begin
          c_cmd = req_cmd; c_addr = req_addr; c_alias = alias_en; c_code = size_code;
          c_lw = line_words; c_narrow = narrow_mode; c_endian = endian_mode;
          m_illegal = c_narrow && (c_endian == 2'b00);
          m_phase = 1;
        end
        1: begin
          if (m_illegal) m_phase = 3;
          else begin
            int bytes, nb;
            logic [31:0] a, pend;
            if (c_cmd == 2'b01) bytes = (c_lw == 0) ? 8 : int'(c_lw) * 4;
            else if (c_cmd == 2'b10) bytes = (pow_amt(c_code) > 32) ? pow_amt(c_code) : 32;
            else if (c_narrow) bytes = 4;
            else bytes = c_alias ? pow_amt(c_code) : 8;
            nb = (bytes + 7) / 8;
            a = c_addr & ~32'h7;
            pend = (c_addr & ~32'hFFF) + 32'h1000;
            m_q.delete();
            for (int i = 0; i < nb && a < pend; i++) begin
              m_q.push_back(a);
              a = a + 8;
            end
            m_be = ((c_cmd == 2'b00 || c_cmd == 2'b11) && c_narrow) ?
                   (c_addr[2] ? 8'hF0 : 8'h0F) : 8'hFF;
            m_phase = 2;
          end
        end
        2: if (beat_ready) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_phase = 3;
        end
        default: m_phase = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R9 req_ready", {31'b0, req_ready}, {31'b0, m_phase == 0});
      check("R8 beat_valid", {31'b0, beat_valid}, {31'b0, m_phase == 2});
      check("R10 done", {31'b0, done}, {31'b0, m_phase == 3});
      check("R7 err", {31'b0, err}, {31'b0, m_phase == 1 && m_illegal});
      if (m_phase == 2 && m_q.size() > 0) begin
        check("R8 R5 beat_addr", beat_addr, m_q[0]);
        check("R6 beat_be", {24'b0, beat_be}, {24'b0, m_be});
      end
    end
  end

  always @(negedge clk) begin
    if (stall_mode == 0) beat_ready <= 1'b1;
    else beat_ready <= (cyc % 3) != 0;
  end

  task automatic run_req(input string tag, input logic [1:0] cmd, input logic [31:0] addr,
                         input logic al, input logic [2:0] code, input logic [7:0] lw,
                         input logic nar, input logic [1:0] endi, input int exp_beats,
                         input bit hold_valid);
    @(negedge clk);
    beats_seen = 0;
    errs_seen = 0;
    req_cmd = cmd; req_addr = addr; alias_en = al; size_code = code;
    line_words = lw; narrow_mode = nar; endian_mode = endi;
    req_valid = 1'b1;
    @(negedge clk);
    if (hold_valid) begin
      req_addr = addr ^ 32'h0000_0800;
      req_cmd = 2'b10;
    end else req_valid = 1'b0;
    for (int w = 0; w < 200; w++) begin
      if (done) break;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check({tag, " beat count"}, beats_seen, exp_beats);
    check({tag, " err count"}, errs_seen, (nar && endi == 2'b00) ? 1 : 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 req_ready", {31'b0, req_ready}, 32'd1);
    check("R11 beat_valid", {31'b0, beat_valid}, 32'd0);
    check("R11 done", {31'b0, done}, 32'd0);
    check("R11 err", {31'b0, err}, 32'd0);

    run_req("R1", 2'b00, 32'h0000_1000, 1'b0, 3'd4, 8'd0, 1'b0, 2'b10, 1, 0);
    run_req("R1", 2'b11, 32'h0000_1234, 1'b0, 3'd0, 8'd0, 1'b0, 2'b01, 1, 0);
    run_req("R2", 2'b00, 32'h0000_2000, 1'b1, 3'd2, 8'd0, 1'b0, 2'b10, 4, 0);
    run_req("R2", 2'b00, 32'h0000_2100, 1'b1, 3'd7, 8'd0, 1'b0, 2'b10, 16, 0);
    run_req("R3", 2'b01, 32'h0000_3000, 1'b0, 3'd0, 8'd8, 1'b0, 2'b10, 4, 0);
    run_req("R3", 2'b01, 32'h0000_3004, 1'b0, 3'd0, 8'd3, 1'b0, 2'b10, 2, 0);
    run_req("R3", 2'b01, 32'h0000_3100, 1'b1, 3'd4, 8'd0, 1'b0, 2'b10, 1, 0);
    run_req("R4", 2'b10, 32'h0000_4000, 1'b0, 3'd0, 8'd0, 1'b0, 2'b10, 4, 0);
    run_req("R4", 2'b10, 32'h0000_4200, 1'b0, 3'd3, 8'd0, 1'b0, 2'b10, 8, 0);
    stall_mode = 1;
    run_req("R5", 2'b10, 32'h0000_2FE8, 1'b1, 3'd4, 8'd0, 1'b0, 2'b10, 3, 0);
    run_req("R5", 2'b00, 32'h0000_3FFC, 1'b1, 3'd4, 8'd0, 1'b0, 2'b10, 1, 0);
    run_req("R6", 2'b00, 32'h0000_0104, 1'b1, 3'd3, 8'd0, 1'b1, 2'b10, 1, 0);
    run_req("R6", 2'b00, 32'h0000_0100, 1'b0, 3'd0, 8'd0, 1'b1, 2'b01, 1, 0);
    run_req("R6", 2'b10, 32'h0000_0500, 1'b0, 3'd0, 8'd0, 1'b1, 2'b11, 4, 0);
    run_req("R7", 2'b00, 32'h0000_0600, 1'b0, 3'd0, 8'd0, 1'b1, 2'b00, 0, 0);
    run_req("R7", 2'b10, 32'h0000_0700, 1'b1, 3'd4, 8'd0, 1'b1, 2'b00, 0, 0);
    run_req("R9", 2'b00, 32'h0000_5000, 1'b1, 3'd3, 8'd0, 1'b0, 2'b10, 8, 1);
    stall_mode = 0;
    run_req("R10", 2'b10, 32'h0000_6FF0, 1'b0, 3'd0, 8'd0, 1'b0, 2'b10, 2, 0);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule